// File: doc/BRIEF.md
# Two-thread decode-slot arbiter

This block picks, each clock cycle, which of two hardware threads may use the single decode and group-formation slot of a core. Only one thread can be granted per cycle. Each thread has a 3-bit software priority. Level 0 means the thread is not running. Level 1 is the lowest running level and level 7 is the highest. When both priorities are equal, the threads take turns. When they differ, the higher thread gets a larger share of the slots, and the share grows with the difference.

Three hardware throttles sit on top of the software setting:
- A thread that holds too many group-table entries has its effective priority lowered by one level.
- A thread with too many outstanding L2 load misses is blocked from decode.
- A thread stalled on a long-latency operation is blocked, and its waiting instructions are flushed.

There are two special modes. In single-thread mode one chosen thread may decode every cycle. When both threads sit at level 1, a power-saving mode allows at most one grant in every 32 cycles.

Priorities and thresholds are loaded through a small register-write port and take effect on the cycle after the write.

Top module: `smt_decode_arb`

## Requirements
- R1: After reset, both priority registers read 0 and both thresholds are all ones. As a result, no grant is issued and no flush is raised.
- R2: A write with `cfg_we_i` high stores `cfg_wdata_i` on the clock edge. Address 0 is the thread-0 priority (bits 2:0) and address 1 is the thread-1 priority (bits 2:0). Address 2 is the group-table threshold and address 3 is the load-miss threshold. The new value is used from the next cycle on, and the old value still applies in the write cycle itself. A write to either priority register restarts the share pattern and the turn bit.
- R3: A thread whose software priority is 0 is never granted. If the other thread is eligible, it receives every slot.
- R4: With equal effective priorities, grants alternate between the threads. Thread 0 goes first after a priority write.
- R5: With an effective priority difference d > 0, grants are counted in windows of 2^(d+1). The higher thread takes the first 2^(d+1)−1 grants of each window and the lower thread takes the last one.
- R6: When a thread's group-table occupancy is strictly greater than the group-table threshold, its effective priority is one level below its software value, but never below 1. The software register is not changed. Occupancy equal to the threshold has no effect.
- R7: When a thread's load-miss count is strictly greater than the load-miss threshold, that thread is not granted. Its slots go to the other thread.
- R8: While `stall_i[t]` is high, thread t is not granted. `flush_o[t]` is high for exactly the one cycle in which `stall_i[t]` rises.
- R9: When both software priorities are 1 and single-thread mode is off, at most one grant is issued every 32 cycles. The first grant comes in the first cycle of that state.
- R10: In single-thread mode, only thread `st_tid_i` may be granted, and it may be granted every cycle.
- R11: If the thread preferred for the slot is not eligible, the slot goes to the other thread when that thread is eligible. If neither thread is eligible, `gnt_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Register write enable |
| cfg_addr_i | input | 2 | Register select: 0/1 thread priority, 2 group-table threshold, 3 load-miss threshold |
| cfg_wdata_i | input | DATA_W | Register write data |
| st_mode_i | input | 1 | Single-thread mode |
| st_tid_i | input | 1 | Active thread in single-thread mode |
| gct_occ_i | input | 2*OCC_W | Group-table occupancy per thread; thread t in bits [t*OCC_W +: OCC_W] |
| l2_miss_i | input | 2*MISS_W | Outstanding L2 load misses per thread; thread t in bits [t*MISS_W +: MISS_W] |
| stall_i | input | 2 | Long-latency stall flag per thread |
| gnt_o | output | 1 | A decode slot is granted this cycle |
| tid_o | output | 1 | Granted thread (0 when there is no grant) |
| flush_o | output | 2 | Per-thread flush request for instructions waiting for dispatch |

## Verification
The assertions check, on every cycle, that a grant never goes to a thread that is:
- at level 0,
- over its load-miss threshold,
- stalled, or
- outside the single-thread selection.

They also check that a flush lasts a single cycle and that power-saving mode never grants in two consecutive cycles.

The exact share patterns can only be shown by the bench scenarios. These cover alternation, the 2^(d+1) windows for several differences and both directions, the one-level drop from group-table congestion, the fallback when the preferred thread is blocked, and the full 32-cycle power-saving period.

// File: rtl/smt_arb_pkg.sv
package smt_arb_pkg;
  localparam int unsigned NUM_THR = 2;
  localparam int unsigned PRIO_W  = 3;

  typedef logic [PRIO_W-1:0] prio_t;

  localparam prio_t PRIO_MIN = prio_t'(1);

  typedef enum logic [1:0] {
    CFG_PRIO0    = 2'd0,
    CFG_PRIO1    = 2'd1,
    CFG_GCT_THR  = 2'd2,
    CFG_MISS_THR = 2'd3
  } cfg_addr_e;

  // one level down, floor at the lowest running level
  function automatic prio_t lower_prio(prio_t p);
    return (p > PRIO_MIN) ? p - prio_t'(1) : p;
  endfunction
endpackage

// File: rtl/smt_arb_cfg.sv
module smt_arb_cfg
  import smt_arb_pkg::*;
#(
  parameter int unsigned OCC_W  = 6,
  parameter int unsigned MISS_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [1:0]                     addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [NUM_THR-1:0][PRIO_W-1:0] prio_o,
  output logic [OCC_W-1:0]               gct_thr_o,
  output logic [MISS_W-1:0]              miss_thr_o,
  output logic                           prio_wr_o
);
  logic [NUM_THR-1:0][PRIO_W-1:0] prio_q;
  logic [OCC_W-1:0]               gct_thr_q;
  logic [MISS_W-1:0]              miss_thr_q;
  logic                           unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
    end else if (we_i) begin
      for (int t = 0; t < NUM_THR; t++) begin
        if (addr_i == 2'(t)) prio_q[t] <= wdata_i[PRIO_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gct_thr_q  <= '1;
      miss_thr_q <= '1;
    end else if (we_i) begin
      if (addr_i == CFG_GCT_THR)  gct_thr_q  <= wdata_i[OCC_W-1:0];
      if (addr_i == CFG_MISS_THR) miss_thr_q <= wdata_i[MISS_W-1:0];
    end
  end

  assign prio_o     = prio_q;
  assign gct_thr_o  = gct_thr_q;
  assign miss_thr_o = miss_thr_q;
  assign prio_wr_o  = we_i && (addr_i == CFG_PRIO0 || addr_i == CFG_PRIO1);
endmodule

// File: rtl/smt_arb_thr.sv
module smt_arb_thr
  import smt_arb_pkg::*;
#(
  parameter int unsigned OCC_W  = 6,
  parameter int unsigned MISS_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  prio_t             sw_prio_i,
  input  logic [OCC_W-1:0]  occ_i,
  input  logic [OCC_W-1:0]  gct_thr_i,
  input  logic [MISS_W-1:0] miss_i,
  input  logic [MISS_W-1:0] miss_thr_i,
  input  logic              stall_i,
  input  logic              st_mode_i,
  input  logic              st_sel_i,
  output prio_t             eff_prio_o,
  output logic              elig_o,
  output logic              flush_o
);
  logic stall_q;
  logic gct_over, miss_over, running;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stall_q <= 1'b0;
    else         stall_q <= stall_i;
  end

  assign gct_over   = occ_i > gct_thr_i;
  assign miss_over  = miss_i > miss_thr_i;
  assign running    = sw_prio_i != '0;
  assign eff_prio_o = gct_over ? lower_prio(sw_prio_i) : sw_prio_i;
  assign elig_o     = running && !miss_over && !stall_i && (!st_mode_i || st_sel_i);
  assign flush_o    = stall_i && !stall_q;
endmodule

// File: rtl/smt_arb_sched.sv
module smt_arb_sched
  import smt_arb_pkg::*;
#(
  parameter int unsigned LP_PERIOD = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_THR-1:0][PRIO_W-1:0] eff_prio_i,
  input  logic [NUM_THR-1:0][PRIO_W-1:0] sw_prio_i,
  input  logic [NUM_THR-1:0]             elig_i,
  input  logic                           st_mode_i,
  input  logic                           st_tid_i,
  input  logic                           prio_wr_i,
  output logic                           gnt_o,
  output logic                           tid_o,
  output logic                           lp_mode_o
);
  localparam int unsigned CNT_W = 1 << PRIO_W;
  localparam int unsigned LP_W  = (LP_PERIOD > 1) ? $clog2(LP_PERIOD) : 1;

  logic [CNT_W-1:0] slot_q, mask;
  logic [LP_W-1:0]  lp_cnt_q;
  logic             turn_q;
  logic             hi, pref, last_slot, lp_ok;
  prio_t            d;

  assign hi = eff_prio_i[1] > eff_prio_i[0];
  assign d  = hi ? eff_prio_i[1] - eff_prio_i[0] : eff_prio_i[0] - eff_prio_i[1];

  always_comb begin
    for (int i = 0; i < CNT_W; i++) mask[i] = (i <= int'(d));
  end

  // lower thread owns the last slot of each window
  assign last_slot = (slot_q & mask) == mask;

  always_comb begin
    if (st_mode_i)     pref = st_tid_i;
    else if (d == '0)  pref = turn_q;
    else if (last_slot) pref = ~hi;
    else               pref = hi;
  end

  assign lp_mode_o = !st_mode_i && sw_prio_i[0] == PRIO_MIN && sw_prio_i[1] == PRIO_MIN;
  assign lp_ok     = !lp_mode_o || lp_cnt_q == '0;

  always_comb begin
    gnt_o = 1'b0;
    tid_o = 1'b0;
    if (lp_ok) begin
      if (elig_i[pref]) begin
        gnt_o = 1'b1;
        tid_o = pref;
      end else if (elig_i[~pref]) begin
        gnt_o = 1'b1;
        tid_o = ~pref;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      turn_q <= 1'b0;
    end else if (prio_wr_i) begin
      slot_q <= '0;
      turn_q <= 1'b0;
    end else if (gnt_o) begin
      slot_q <= slot_q + 1'b1;
      turn_q <= ~tid_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              lp_cnt_q <= '0;
    else if (!lp_mode_o)                      lp_cnt_q <= '0;
    else if (lp_cnt_q == LP_W'(LP_PERIOD - 1)) lp_cnt_q <= '0;
    else                                      lp_cnt_q <= lp_cnt_q + 1'b1;
  end
endmodule

// File: rtl/smt_decode_arb.sv
module smt_decode_arb
  import smt_arb_pkg::*;
#(
  parameter int unsigned OCC_W     = 6,
  parameter int unsigned MISS_W    = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned LP_PERIOD = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cfg_we_i,
  input  logic [1:0]                cfg_addr_i,
  input  logic [DATA_W-1:0]         cfg_wdata_i,
  input  logic                      st_mode_i,
  input  logic                      st_tid_i,
  input  logic [NUM_THR*OCC_W-1:0]  gct_occ_i,
  input  logic [NUM_THR*MISS_W-1:0] l2_miss_i,
  input  logic [NUM_THR-1:0]        stall_i,
  output logic                      gnt_o,
  output logic                      tid_o,
  output logic [NUM_THR-1:0]        flush_o
);
  logic [NUM_THR-1:0][PRIO_W-1:0] sw_prio, eff_prio;
  logic [NUM_THR-1:0]             elig;
  logic [OCC_W-1:0]               gct_thr;
  logic [MISS_W-1:0]              miss_thr;
  logic                           prio_wr, lp_mode;

  smt_arb_cfg #(.OCC_W(OCC_W), .MISS_W(MISS_W), .DATA_W(DATA_W)) i_cfg (
    .clk_i, .rst_ni,
    .we_i      (cfg_we_i),
    .addr_i    (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .prio_o    (sw_prio),
    .gct_thr_o (gct_thr),
    .miss_thr_o(miss_thr),
    .prio_wr_o (prio_wr)
  );

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    smt_arb_thr #(.OCC_W(OCC_W), .MISS_W(MISS_W)) i_thr (
      .clk_i, .rst_ni,
      .sw_prio_i (sw_prio[t]),
      .occ_i     (gct_occ_i[t*OCC_W +: OCC_W]),
      .gct_thr_i (gct_thr),
      .miss_i    (l2_miss_i[t*MISS_W +: MISS_W]),
      .miss_thr_i(miss_thr),
      .stall_i   (stall_i[t]),
      .st_mode_i (st_mode_i),
      .st_sel_i  (st_tid_i == 1'(t)),
      .eff_prio_o(eff_prio[t]),
      .elig_o    (elig[t]),
      .flush_o   (flush_o[t])
    );
  end

  smt_arb_sched #(.LP_PERIOD(LP_PERIOD)) i_sched (
    .clk_i, .rst_ni,
    .eff_prio_i(eff_prio),
    .sw_prio_i (sw_prio),
    .elig_i    (elig),
    .st_mode_i (st_mode_i),
    .st_tid_i  (st_tid_i),
    .prio_wr_i (prio_wr),
    .gnt_o     (gnt_o),
    .tid_o     (tid_o),
    .lp_mode_o (lp_mode)
  );
endmodule

// File: rtl/smt_decode_arb_chk.sv
module smt_decode_arb_chk
  import smt_arb_pkg::*;
#(
  parameter int unsigned MISS_W = 4
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           gnt_i,
  input logic                           tid_i,
  input logic [NUM_THR-1:0]             flush_i,
  input logic [NUM_THR-1:0]             stall_i,
  input logic                           st_mode_i,
  input logic                           st_tid_i,
  input logic [NUM_THR*MISS_W-1:0]      l2_miss_i,
  input logic [MISS_W-1:0]              miss_thr_i,
  input logic [NUM_THR-1:0][PRIO_W-1:0] sw_prio_i,
  input logic                           lp_i
);
  AST_NO_IDLE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_i |-> sw_prio_i[tid_i] != '0); // R3

  AST_MISS_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_i |-> !(l2_miss_i[tid_i*MISS_W +: MISS_W] > miss_thr_i)); // R7

  AST_STALL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_i |-> !stall_i[tid_i]); // R8

  AST_ST_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_mode_i && gnt_i) |-> tid_i == st_tid_i); // R10

  AST_LP_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_i && gnt_i) |=> (!lp_i || !gnt_i)); // R9

  for (genvar t = 0; t < NUM_THR; t++) begin : g_fl
    AST_FLUSH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i[t] |=> !flush_i[t]); // R8
  end
endmodule

bind smt_decode_arb smt_decode_arb_chk #(.MISS_W(MISS_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .gnt_i     (gnt_o),
  .tid_i     (tid_o),
  .flush_i   (flush_o),
  .stall_i   (stall_i),
  .st_mode_i (st_mode_i),
  .st_tid_i  (st_tid_i),
  .l2_miss_i (l2_miss_i),
  .miss_thr_i(miss_thr),
  .sw_prio_i (sw_prio),
  .lp_i      (lp_mode)
);

// File: tb/test_smt_decode_arb.sv
module test_smt_decode_arb;
  localparam int OCC_W  = 6;
  localparam int MISS_W = 4;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_addr = '0;
  logic [DATA_W-1:0] cfg_wd = '0;
  logic              st_mode = 1'b0;
  logic              st_tid = 1'b0;
  logic [2*OCC_W-1:0]  gct_occ = '0;
  logic [2*MISS_W-1:0] l2_miss = '0;
  logic [1:0]        stall = '0;
  logic              gnt, tid;
  logic [1:0]        flush;

  always #5 clk = ~clk;

  smt_decode_arb i_smt_decode_arb (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wd),
    .st_mode_i(st_mode), .st_tid_i(st_tid),
    .gct_occ_i(gct_occ), .l2_miss_i(l2_miss), .stall_i(stall),
    .gnt_o(gnt), .tid_o(tid), .flush_o(flush)
  );

  typedef struct {
    string      req;
    logic       gnt;
    logic       tid;
    logic [1:0] flush;
  } exp_t;

  exp_t exp_q[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  // monitor: compare mid-cycle, away from the active edge
  always @(negedge clk) begin
    exp_t e;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      n_run++;
      if (gnt !== e.gnt || (e.gnt && tid !== e.tid) || flush !== e.flush) begin
        n_fail++;
        $display("FAIL %s: gnt=%0b tid=%0d flush=%b, expected gnt=%0b tid=%0d flush=%b",
                 e.req, gnt, tid, flush, e.gnt, e.tid, e.flush);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_c(input string r, input logic g, input logic t, input logic [1:0] f);
    exp_q.push_back('{r, g, t, f});
    step();
  endtask

  task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wd = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state is idle
    expect_c("R1", 0, 0, 2'b00);
    expect_c("R1", 0, 0, 2'b00);
    // R2: the write cycle still sees the old priority (0)
    cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wd = 8'd4;
    expect_c("R2", 0, 0, 2'b00);
    cfg_we = 1'b0;
    // R3: thread 1 at level 0, thread 0 takes every slot
    repeat (4) expect_c("R3", 1, 0, 2'b00);
    // R4: equal priorities alternate, thread 0 first
    wr(2'd1, 8'd4);
    repeat (3) begin
      expect_c("R4", 1, 0, 2'b00);
      expect_c("R4", 1, 1, 2'b00);
    end
    // R5: d=2, window of 8, thread 0 higher
    wr(2'd0, 8'd6);
    repeat (2) begin
      repeat (7) expect_c("R5", 1, 0, 2'b00);
      expect_c("R5", 1, 1, 2'b00);
    end
    // R5: d=1, thread 1 higher
    wr(2'd0, 8'd3);
    repeat (2) begin
      repeat (3) expect_c("R5", 1, 1, 2'b00);
      expect_c("R5", 1, 0, 2'b00);
    end
    // R6: occupancy 11 > 10 drops thread 0 from 5 to 4
    gct_occ = {6'd0, 6'd11};
    wr(2'd2, 8'd10);
    wr(2'd0, 8'd5);
    wr(2'd1, 8'd5);
    repeat (3) expect_c("R6", 1, 1, 2'b00);
    expect_c("R6", 1, 0, 2'b00);
    // R6: occupancy equal to threshold has no effect
    gct_occ = {6'd0, 6'd10};
    wr(2'd1, 8'd5);
    expect_c("R6", 1, 0, 2'b00);
    expect_c("R6", 1, 1, 2'b00);
    gct_occ = '0;
    // R7: thread 1 over the miss threshold is blocked
    wr(2'd3, 8'd3);
    l2_miss = {4'd4, 4'd0};
    wr(2'd1, 8'd5);
    repeat (4) expect_c("R7", 1, 0, 2'b00);
    l2_miss = {4'd3, 4'd0};
    wr(2'd1, 8'd5);
    expect_c("R7", 1, 0, 2'b00);
    expect_c("R7", 1, 1, 2'b00);
    l2_miss = '0;
    // R8: stall rise flushes once, slots move to thread 1
    wr(2'd1, 8'd5);
    stall = 2'b01;
    expect_c("R8", 1, 1, 2'b01);
    expect_c("R8", 1, 1, 2'b00);
    // R11: both blocked, no grant
    stall = 2'b11;
    expect_c("R11", 0, 0, 2'b10);
    expect_c("R11", 0, 0, 2'b00);
    stall = 2'b00;
    expect_c("R11", 1, 0, 2'b00);
    // R10: single-thread mode grants thread 1 every cycle
    st_mode = 1'b1; st_tid = 1'b1;
    wr(2'd1, 8'd5);
    repeat (4) expect_c("R10", 1, 1, 2'b00);
    st_tid = 1'b0;
    wr(2'd0, 8'd0);
    repeat (2) expect_c("R10", 0, 0, 2'b00);
    st_mode = 1'b0;
    // R9: both at level 1, one grant per 32 cycles
    wr(2'd0, 8'd1);
    wr(2'd1, 8'd1);
    expect_c("R9", 1, 0, 2'b00);
    repeat (31) expect_c("R9", 0, 0, 2'b00);
    expect_c("R9", 1, 1, 2'b00);
    step();
    done = 1'b1;
    finish_run();
  end
endmodule